// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This block sits between a host register interface and a byte-wide card data port and moves transfer data through a small word FIFO. The host starts a transfer by writing the data-control fields (enable and direction) together with a byte length, then either pushes words into the FIFO for the card to consume, or pops words that the engine has assembled from card bytes. The engine runs one card byte per clock while its conditions allow, keeps a count of bytes still to move, and finishes on its own once nothing is left to move.

Words and bytes are related in little-endian order in both directions. For card reads, incoming bytes fill a word from the least significant byte up, and a partly filled final word is still committed. For card writes, each word taken from the FIFO goes out least significant byte first. A set of occupancy flags is reported for the active direction only. To suit host software that cannot cope with the FIFO refilling under it, every host pop pauses card-to-FIFO filling until the host next polls the status or the word count.

Top module: `cardxfer_top`

## Requirements
- R1: After reset the engine is disabled, the FIFO is empty, the remaining count is zero, every FIFO flag and both end flags are 0 and neither card strobe is active.
- R2: A control write with the enable set loads the remaining count from `lenIn` at that clock edge, clears both end flags and restarts byte packing and unpacking; a control write with the enable clear stops the engine.
- R3: In the read direction each card byte taken (`cardRdStrobe` high) is placed in byte lane k of the word being built, lane 0 being bits 7:0 and the lanes filled in rising order; the word is pushed after lane 3 or after the final byte of the transfer, upper lanes of a short word reading as zero.
- R4: In the write direction each byte sent (`cardWrStrobe` high) is the next byte of the oldest FIFO word, bits 7:0 first; the remaining count drops by one for every byte moved in either direction, one byte per cycle at most.
- R5: While enabled with a remaining count of zero, both end flags (`endFlags` bit 0 data end, bit 1 block end) become 1 at the next edge and stay 1 until the next control write with enable set.
- R6: While enabled, the engine clears its own enable at the edge where the remaining count and the FIFO level are both zero; the FIFO flags are all zero whenever the engine is disabled or has nothing left to move.
- R7: `fifoFlags` bit layout: write direction uses bits 4:0 = {data available, empty, full, half-empty (level at most 8), active}; read direction uses bits 9:5 = {data available, empty, full, half-full (level at least 8), active}; the group of the other direction reads as zero.
- R8: A host pop of a non-empty FIFO stops card read steps from the next cycle on; a `statusPoll` pulse releases the hold from the next cycle; a pop and a poll in the same cycle leave the hold set.
- R9: `fifoWords` equals the remaining byte count rounded up to whole words, (count + 3) >> 2.
- R10: A host push is ignored when the remaining count is zero, in the read direction, or when the FIFO is full; a host pop of an empty FIFO returns zero and leaves the level unchanged.
- R11: A card read step happens only while enabled in the read direction with bytes remaining, `cardRdReady` high, no hold and the FIFO not full; a card write step needs a partly sent word or a FIFO word that the host is not popping in the same cycle.
- R12: The FIFO keeps 16 words in first-in first-out order across pointer wrap, and its level never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrite | input | 1 | Data-control write strobe |
| ctrlEnable | input | 1 | Enable value written with `ctrlWrite` |
| ctrlDirRead | input | 1 | Direction written with `ctrlWrite` (1 = card to host) |
| lenIn | input | 16 | Transfer length in bytes |
| hostPush | input | 1 | Host pushes `hostPushData` into the FIFO |
| hostPushData | input | 32 | Word pushed by the host |
| hostPop | input | 1 | Host pops the oldest FIFO word |
| hostPopData | output | 32 | Oldest FIFO word, zero when empty |
| statusPoll | input | 1 | Host read of status or word count; releases the hold |
| cardRdReady | input | 1 | Card has a byte ready |
| cardRdData | input | 8 | Byte offered by the card |
| cardRdStrobe | output | 1 | Byte taken from the card this cycle |
| cardWrStrobe | output | 1 | Byte sent to the card this cycle |
| cardWrData | output | 8 | Byte sent to the card |
| xferEnable | output | 1 | Engine enabled |
| remCount | output | 16 | Bytes still to move |
| fifoWords | output | 16 | Remaining count rounded up to words |
| fifoLevel | output | 5 | FIFO occupancy in words |
| fifoFlags | output | 10 | Direction-specific FIFO flags |
| endFlags | output | 2 | Data-end and block-end flags |

## Verification
The bench builds the block with its defaults, a 16-word FIFO of 32-bit words and a 16-bit length, so an 80-byte read fills the FIFO within 64 card cycles and exposes the full stall, the half-full threshold and pointer wrap while draining. Four-byte words make the short final word of a 5-byte read and the abandoned tail of a 10-byte write reachable with a handful of pushes. A behavioural queue model predicts every output on every clock, and directed checks pin down byte order, the pop hold and its release, ignored pushes and empty pops.

// File: rtl/cardxfer_pkg.sv
package cardxfer_pkg;
  // Strobes from the control to the FIFO datapath.
  typedef struct packed {
    logic push;     // write one word at the tail
    logic pop;      // drop the head word
    logic selCard;  // pushed word comes from the card packer
  } fifoCmd_t;
endpackage

// File: rtl/cardxfer_fifo.sv
module cardxfer_fifo
  import cardxfer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] hostWord,
  input  logic [DATA_W-1:0] cardWord,
  output logic [DATA_W-1:0] headWord,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic [DATA_W-1:0] inWord;

  // Tail index is head plus occupancy, wrapping with the power-of-two depth.
  assign wrPtr    = rdPtr + level[PTR_W-1:0];
  assign inWord   = cmd.selCard ? cardWord : hostWord;
  assign headWord = store[rdPtr];

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= inWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (cmd.pop) rdPtr <= rdPtr + 1'b1;
      case ({cmd.push, cmd.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cardxfer_ctrl.sv
module cardxfer_ctrl
  import cardxfer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              ctrlEnable,
  input  logic              ctrlDirRead,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              hostPush,
  input  logic              hostPop,
  input  logic              statusPoll,
  input  logic              cardRdReady,
  input  logic [7:0]        cardRdData,
  input  logic [LVL_W-1:0]  level,
  input  logic [DATA_W-1:0] headWord,
  output fifoCmd_t          cmd,
  output logic [DATA_W-1:0] cardWord,
  output logic [DATA_W-1:0] hostPopData,
  output logic              cardRdStrobe,
  output logic              cardWrStrobe,
  output logic [7:0]        cardWrData,
  output logic              xferEnable,
  output logic [LEN_W-1:0]  remCount,
  output logic [LEN_W-1:0]  fifoWords,
  output logic [9:0]        fifoFlags,
  output logic [1:0]        endFlags
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int HALF   = DEPTH / 2;

  logic              xferOn, dirRead, holdOff, doneReg;
  logic [LEN_W-1:0]  remCnt;
  logic [LANE_W-1:0] packLane, sendLeft;
  logic [DATA_W-1:0] packReg, shiftReg, packNext;
  logic              cntZero, fifoEmpty, fifoFull, lastByte;
  logic              hostPopOk, hostPushOk, rdStep, wrStep, wrLoad, packPush;
  logic              active, halfLow, halfHigh;
  logic [4:0]        txGrp, rxGrp;
  logic [LEN_W:0]    roundUp;

  assign cntZero   = (remCnt == '0);
  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign lastByte  = (remCnt == LEN_W'(1));

  assign hostPopOk  = hostPop && !fifoEmpty;
  assign hostPushOk = hostPush && !cntZero && !dirRead && !fifoFull;

  assign rdStep = xferOn && dirRead && !cntZero && cardRdReady && !holdOff
                  && !fifoFull && !ctrlWrite;
  assign wrStep = xferOn && !dirRead && !cntZero && !ctrlWrite
                  && ((sendLeft != '0) || (!fifoEmpty && !hostPop));
  assign wrLoad = wrStep && (sendLeft == '0);

  // Little-endian packing: lane k lands at bits 8k+7:8k.
  assign packNext = packReg | (DATA_W'(cardRdData) << {packLane, 3'b000});
  assign packPush = rdStep && ((packLane == LANE_W'(LANES - 1)) || lastByte);

  assign cmd.push    = hostPushOk | packPush;
  assign cmd.pop     = hostPopOk | wrLoad;
  assign cmd.selCard = packPush;

  assign cardWord     = packNext;
  assign hostPopData  = fifoEmpty ? '0 : headWord;
  assign cardRdStrobe = rdStep;
  assign cardWrStrobe = wrStep;
  assign cardWrData   = wrLoad ? headWord[7:0] : shiftReg[7:0];

  assign xferEnable = xferOn;
  assign remCount   = remCnt;
  assign endFlags   = {2{doneReg}};
  assign roundUp    = {1'b0, remCnt} + (LEN_W + 1)'(LANES - 1);
  assign fifoWords  = LEN_W'(roundUp >> LANE_W);

  assign active   = xferOn && !(cntZero && fifoEmpty);
  assign halfLow  = (level <= LVL_W'(HALF));
  assign halfHigh = (level >= LVL_W'(HALF));
  assign txGrp    = {!fifoEmpty, fifoEmpty, fifoFull, halfLow, 1'b1};
  assign rxGrp    = {!fifoEmpty, fifoEmpty, fifoFull, halfHigh, 1'b1};
  assign fifoFlags = !active ? '0 : (dirRead ? {rxGrp, 5'b0} : {5'b0, txGrp});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferOn   <= 1'b0;
      dirRead  <= 1'b0;
      holdOff  <= 1'b0;
      doneReg  <= 1'b0;
      remCnt   <= '0;
      packLane <= '0;
      sendLeft <= '0;
      packReg  <= '0;
      shiftReg <= '0;
    end else begin
      // A pop wins over a poll landing in the same cycle.
      if (hostPopOk)       holdOff <= 1'b1;
      else if (statusPoll) holdOff <= 1'b0;

      if (ctrlWrite) begin
        xferOn  <= ctrlEnable;
        dirRead <= ctrlDirRead;
        if (ctrlEnable) begin
          remCnt   <= lenIn;
          packLane <= '0;
          packReg  <= '0;
          sendLeft <= '0;
          doneReg  <= 1'b0;
        end
      end else begin
        if (xferOn && cntZero) begin
          doneReg <= 1'b1;
          if (fifoEmpty) xferOn <= 1'b0;
        end
        if (rdStep) begin
          remCnt <= remCnt - 1'b1;
          if (packPush) begin
            packReg  <= '0;
            packLane <= '0;
          end else begin
            packReg  <= packNext;
            packLane <= packLane + 1'b1;
          end
        end
        if (wrStep) begin
          remCnt <= remCnt - 1'b1;
          if (wrLoad) begin
            shiftReg <= headWord >> 8;
            sendLeft <= LANE_W'(LANES - 1);
          end else begin
            shiftReg <= shiftReg >> 8;
            sendLeft <= sendLeft - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cardxfer_top.sv
module cardxfer_top
  import cardxfer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              ctrlEnable,
  input  logic              ctrlDirRead,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              hostPush,
  input  logic [DATA_W-1:0] hostPushData,
  input  logic              hostPop,
  output logic [DATA_W-1:0] hostPopData,
  input  logic              statusPoll,
  input  logic              cardRdReady,
  input  logic [7:0]        cardRdData,
  output logic              cardRdStrobe,
  output logic              cardWrStrobe,
  output logic [7:0]        cardWrData,
  output logic              xferEnable,
  output logic [LEN_W-1:0]  remCount,
  output logic [LEN_W-1:0]  fifoWords,
  output logic [$clog2(DEPTH+1)-1:0] fifoLevel,
  output logic [9:0]        fifoFlags,
  output logic [1:0]        endFlags
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  fifoCmd_t          fifoCmd;
  logic [DATA_W-1:0] cardWord;
  logic [DATA_W-1:0] headWord;

  cardxfer_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) fifo_i (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .hostWord(hostPushData),
    .cardWord(cardWord), .headWord(headWord), .level(fifoLevel)
  );

  cardxfer_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
    .ctrlDirRead(ctrlDirRead), .lenIn(lenIn), .hostPush(hostPush),
    .hostPop(hostPop), .statusPoll(statusPoll), .cardRdReady(cardRdReady),
    .cardRdData(cardRdData), .level(fifoLevel), .headWord(headWord),
    .cmd(fifoCmd), .cardWord(cardWord), .hostPopData(hostPopData),
    .cardRdStrobe(cardRdStrobe), .cardWrStrobe(cardWrStrobe),
    .cardWrData(cardWrData), .xferEnable(xferEnable), .remCount(remCount),
    .fifoWords(fifoWords), .fifoFlags(fifoFlags), .endFlags(endFlags)
  );
endmodule

// File: rtl/cardxfer_chk.sv
module cardxfer_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrite,
  input logic             ctrlEnable,
  input logic [LEN_W-1:0] lenIn,
  input logic             hostPush,
  input logic             cardRdStrobe,
  input logic             cardWrStrobe,
  input logic             xferEnable,
  input logic [LEN_W-1:0] remCount,
  input logic [LVL_W-1:0] fifoLevel,
  input logic [1:0]       endFlags
);
  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  assert_one_direction_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(cardRdStrobe && cardWrStrobe));

  assert_no_fill_when_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(DEPTH)) |-> !cardRdStrobe);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cardRdStrobe || cardWrStrobe) |=> (remCount == LEN_W'($past(remCount) - 1'b1)));

  assert_length_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && ctrlEnable) |=> (remCount == $past(lenIn)));

  assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xferEnable && remCount == '0 && fifoLevel == '0 && !ctrlWrite) |=> !xferEnable);

  assert_end_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (endFlags[0] && !(ctrlWrite && ctrlEnable)) |=> endFlags[0]);

  assert_idle_push_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostPush && remCount == '0) |=> (fifoLevel <= $past(fifoLevel)));
endmodule

bind cardxfer_top cardxfer_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
  .lenIn(lenIn), .hostPush(hostPush), .cardRdStrobe(cardRdStrobe),
  .cardWrStrobe(cardWrStrobe), .xferEnable(xferEnable), .remCount(remCount),
  .fifoLevel(fifoLevel), .endFlags(endFlags)
);

// File: tb/cardxfer_top_tb_top.sv
module cardxfer_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrite = 1'b0, ctrlEnable = 1'b0, ctrlDirRead = 1'b0;
  logic [15:0] lenIn = '0;
  logic        hostPush = 1'b0, hostPop = 1'b0, statusPoll = 1'b0;
  logic [31:0] hostPushData = '0;
  logic        cardRdReady = 1'b0;
  logic [7:0]  cardRdData;
  logic [31:0] hostPopData;
  logic        cardRdStrobe, cardWrStrobe, xferEnable;
  logic [7:0]  cardWrData;
  logic [15:0] remCount, fifoWords;
  logic [4:0]  fifoLevel;
  logic [9:0]  fifoFlags;
  logic [1:0]  endFlags;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cardxfer_top dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
    .ctrlDirRead(ctrlDirRead), .lenIn(lenIn), .hostPush(hostPush),
    .hostPushData(hostPushData), .hostPop(hostPop), .hostPopData(hostPopData),
    .statusPoll(statusPoll), .cardRdReady(cardRdReady), .cardRdData(cardRdData),
    .cardRdStrobe(cardRdStrobe), .cardWrStrobe(cardWrStrobe),
    .cardWrData(cardWrData), .xferEnable(xferEnable), .remCount(remCount),
    .fifoWords(fifoWords), .fifoLevel(fifoLevel), .fifoFlags(fifoFlags),
    .endFlags(endFlags)
  );

  // Card byte source: base plus number of bytes taken since restart.
  logic [7:0] rdBase = 8'h21;
  logic [7:0] rdOff = '0;
  logic       rdRestart = 1'b0;
  assign cardRdData = rdBase + rdOff;
  always @(posedge clk) begin
    if (rdRestart) rdOff <= '0;
    else if (cardRdStrobe) rdOff <= rdOff + 8'd1;
  end

  // Card byte sink.
  logic [7:0] sentBytes [64];
  int         sentN = 0;
  logic       capClr = 1'b0;
  always @(posedge clk) begin
    if (capClr) sentN <= 0;
    else if (cardWrStrobe) begin
      sentBytes[sentN[5:0]] <= cardWrData;
      sentN <= sentN + 1;
    end
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, compared at every falling edge.
  logic [31:0] mq[$];
  bit          modelOn = 1'b0;
  bit          mEn = 0, mDir = 0, mHold = 0, mDone = 0;
  int          mCnt = 0, mLane = 0, mLeft = 0;
  logic [31:0] mPack = '0, mShift = '0;
  int          eSz;
  bit          eCz, eFull, ePopOk, ePushOk, eRs, eWs, eAct;
  logic [31:0] eHead, eWord;
  logic [7:0]  eWb;
  logic [9:0]  eFlags;

  always @(negedge clk) begin
    if (modelOn) begin
      eSz     = mq.size();
      eCz     = (mCnt == 0);
      eFull   = (eSz == 16);
      eHead   = (eSz > 0) ? mq[0] : 32'h0;
      ePopOk  = hostPop && (eSz > 0);
      ePushOk = hostPush && !eCz && !mDir && !eFull;
      eRs     = mEn && mDir && !eCz && cardRdReady && !mHold && !eFull && !ctrlWrite;
      eWs     = mEn && !mDir && !eCz && !ctrlWrite && (mLeft != 0 || (eSz > 0 && !hostPop));
      eWb     = (mLeft == 0) ? eHead[7:0] : mShift[7:0];
      eAct    = mEn && !(eCz && eSz == 0);
      eFlags  = '0;
      if (eAct) begin
        if (mDir) eFlags = {eSz > 0, eSz == 0, eFull, eSz >= 8, 1'b1, 5'b0};
        else      eFlags = {5'b0, eSz > 0, eSz == 0, eFull, eSz <= 8, 1'b1};
      end

      chk("R11 card read strobe", cardRdStrobe, eRs);
      chk("R4 card write strobe", cardWrStrobe, eWs);
      if (eWs) chk("R4 card write byte", cardWrData, eWb);
      chk("R10 pop data", hostPopData, eHead);
      chk("R6 enable", xferEnable, mEn);
      chk("R2 remaining count", remCount, mCnt);
      chk("R9 word count", fifoWords, (mCnt + 3) >> 2);
      chk("R12 level", fifoLevel, eSz);
      chk("R7 flags", fifoFlags, eFlags);
      chk("R5 end flags", endFlags, {mDone, mDone});

      if (ePopOk) void'(mq.pop_front());
      if (eWs) begin
        if (mLeft == 0) begin
          eWord  = mq.pop_front();
          mShift = eWord >> 8;
          mLeft  = 3;
        end else begin
          mShift = mShift >> 8;
          mLeft--;
        end
        mCnt--;
      end
      if (eRs) begin
        eWord = mPack | (32'(cardRdData) << (8 * mLane));
        if (mLane == 3 || mCnt == 1) begin
          mq.push_back(eWord);
          mPack = '0;
          mLane = 0;
        end else begin
          mPack = eWord;
          mLane++;
        end
        mCnt--;
      end
      if (ePushOk) mq.push_back(hostPushData);
      if (ePopOk) mHold = 1;
      else if (statusPoll) mHold = 0;
      if (ctrlWrite) begin
        mEn  = ctrlEnable;
        mDir = ctrlDirRead;
        if (ctrlEnable) begin
          mCnt = lenIn; mLane = 0; mPack = '0; mLeft = 0; mDone = 0;
        end
      end else if (mEn && eCz) begin
        mDone = 1;
        if (eSz == 0) mEn = 0;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ctrl(bit en, bit dir, int len);
    lenIn = 16'(len); ctrlEnable = en; ctrlDirRead = dir; ctrlWrite = 1'b1;
    tick();
    ctrlWrite = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    modelOn = 1'b1;
    // R1: reset state
    chk("R1 enable after reset", xferEnable, 0);
    chk("R1 level after reset", fifoLevel, 0);
    chk("R1 count after reset", remCount, 0);
    chk("R1 flags after reset", {fifoFlags, endFlags, cardRdStrobe, cardWrStrobe}, 0);

    // Zero-length transfer: R5 and R6
    ctrl(1, 0, 0);
    chk("R2 zero length load", remCount, 0);
    tick();
    chk("R5 end flags on zero length", endFlags, 2'b11);
    chk("R6 self clear on zero length", xferEnable, 0);

    // Write direction, 10 bytes from three words
    capClr = 1'b1; tick(); capClr = 1'b0;
    ctrl(1, 0, 10);
    chk("R2 length load", remCount, 10);
    chk("R5 end flags cleared by enable", endFlags, 0);
    chk("R9 words for 10 bytes", fifoWords, 3);
    chk("R7 write flags empty", fifoFlags, 10'h00B);
    hostPush = 1'b1;
    hostPushData = 32'h44332211; tick();
    hostPushData = 32'h88776655; tick();
    hostPushData = 32'hCCBBAA99; tick();
    hostPush = 1'b0;
    for (int i = 0; i < 40 && xferEnable; i++) tick();
    chk("R4 bytes sent", sentN, 10);
    for (int i = 0; i < 10; i++)
      chk("R4 byte order", sentBytes[i], 8'h11 * (i + 1));
    chk("R6 self clear after write", xferEnable, 0);
    hostPush = 1'b1; hostPushData = 32'hDEADBEEF; tick(); hostPush = 1'b0;
    chk("R10 push ignored at zero count", fifoLevel, 0);

    // Read direction, 5 bytes with a stuttering card
    rdBase = 8'h21; rdRestart = 1'b1; tick(); rdRestart = 1'b0;
    ctrl(1, 1, 5);
    chk("R9 words for 5 bytes", fifoWords, 2);
    for (int i = 0; i < 30 && remCount != 0; i++) begin
      cardRdReady = i[0];
      tick();
    end
    cardRdReady = 1'b0;
    chk("R3 words pushed", fifoLevel, 2);
    chk("R3 packed word", hostPopData, 32'h24232221);
    hostPop = 1'b1; tick(); hostPop = 1'b0;
    chk("R3 short last word", hostPopData, 32'h00000025);
    hostPop = 1'b1; tick(); hostPop = 1'b0;
    chk("R10 empty pop data", hostPopData, 0);
    hostPop = 1'b1; tick(); hostPop = 1'b0;
    chk("R10 empty pop keeps level", fifoLevel, 0);
    tick();
    chk("R6 self clear after read", xferEnable, 0);
    statusPoll = 1'b1; tick(); statusPoll = 1'b0;

    // Read 80 bytes: full stall, pop hold, release, drain across wrap
    rdBase = 8'h40; rdRestart = 1'b1; tick(); rdRestart = 1'b0;
    ctrl(1, 1, 80);
    cardRdReady = 1'b1;
    for (int i = 0; i < 100 && fifoLevel != 16; i++) tick();
    tick(); tick();
    chk("R12 fifo full", fifoLevel, 16);
    chk("R11 stalled count", remCount, 16);
    chk("R7 read flags full", fifoFlags, 10'h2E0);
    chk("R11 no read when full", cardRdStrobe, 0);
    chk("R3 first word", hostPopData, 32'h43424140);
    hostPop = 1'b1; tick(); hostPop = 1'b0;
    repeat (6) tick();
    chk("R8 hold blocks refill", fifoLevel, 15);
    statusPoll = 1'b1; tick(); statusPoll = 1'b0;
    repeat (6) tick();
    chk("R8 poll releases hold", fifoLevel, 16);
    for (int i = 0; i < 80 && xferEnable; i++) begin
      if (fifoLevel != 0) begin
        hostPop = 1'b1; tick(); hostPop = 1'b0;
      end
      statusPoll = 1'b1; tick(); statusPoll = 1'b0;
    end
    chk("R5 end flags after drain", endFlags, 2'b11);
    chk("R6 self clear after drain", xferEnable, 0);
    chk("R2 count exhausted", remCount, 0);
    cardRdReady = 1'b0;
    tick(); tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule